// File: doc/BRIEF.md
# Isochronous Receive Status Tracker

This block follows host-side isochronous IN reception for one endpoint, one microframe at a time. A packet decoder reports each finished data packet with its data PID code and its CRC and bit-stuff error indications. A start-of-microframe strobe marks microframe boundaries, and the receive buffer acknowledges each committed packet. The first packet of a microframe sets how many packets that microframe should carry. Each later packet is checked against the descending PID order that the first packet implies.

Every received packet is committed to the receive buffer, including a corrupt one. Errors are recorded in sticky status bits: corrupt data, a microframe that ended short, and a PID out of sequence. Software reads these bits and clears them with write-one-to-clear pulses. Each buffer acknowledge raises an interrupt, whatever errors were seen, so the data can always be read out. The interrupt stays up until software acknowledges it.

Top module: `iso_rx_tracker`

## Requirements
- R1: While reset is asserted and after it is released, with no activity, `rx_status`, `irq` and `fifo_commit` are all zero.
- R2: Every `pkt_end` pulse gives a one-cycle `fifo_commit` pulse in the following cycle, whether or not the packet had errors. `fifo_commit` is never high at any other time.
- R3: A `pkt_end` with `pkt_crc_err` or `pkt_stuff_err` high sets `rx_status[3]` (data error) in the following cycle.
- R4: The first packet of a microframe sets the expected packet count from its PID code: 2'b10 (DATA2) gives 3, 2'b01 (DATA1) gives 2, and 2'b00 (DATA0) gives 1. Code 2'b11 gives 0.
- R5: When `sof` arrives and fewer packets have been received since the previous `sof` than R4 predicted, `rx_status[2]` (incomplete) is set in the following cycle.
- R6: After the first packet, the packet with 0-based index i must carry PID code (expected count − 1 − i). A packet that breaks this rule sets `rx_status[4]` (PID error) in the following cycle. So does a packet beyond the expected count, or a packet with code 2'b11.
- R7: `sof` clears the packet counter and the expected count after the R5 check. A `pkt_end` in the same cycle as `sof` is the first packet of the new microframe.
- R8: A one on `clr_w1c[k]` clears status bit k, for k in 2, 3 and 4. A set in the same cycle wins over the clear. All other `rx_status` bits are always zero, and clear pulses on them have no effect.
- R9: A `fifo_ack` sets `irq` in the following cycle regardless of any error flag. `irq` holds until `irq_ack`, and an ack in the same cycle as a new `fifo_ack` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sof | input | 1 | Start-of-microframe strobe |
| pkt_end | input | 1 | End of a received data packet; qualifies the fields below |
| pkt_pid | input | 2 | Data PID code: 00 DATA0, 01 DATA1, 10 DATA2, 11 other |
| pkt_crc_err | input | 1 | CRC error on the packet |
| pkt_stuff_err | input | 1 | Bit-stuff error on the packet |
| fifo_ack | input | 1 | Receive buffer acknowledges a committed packet |
| clr_w1c | input | 8 | Write-one-to-clear mask for `rx_status` |
| irq_ack | input | 1 | Software acknowledge of the interrupt |
| fifo_commit | output | 1 | Request to commit the packet just received |
| rx_status | output | 8 | Status: bit 2 incomplete, bit 3 data error, bit 4 PID error |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench checks microframes that end one or two packets short after a DATA2 or DATA1 opener. A design that counted wrongly would miss the incomplete flag or raise it on a full microframe. It sends repeated DATA0 packets, an extra packet after a complete sequence, and the reserved code. A lax order check would leave the PID error clear. It puts a packet in the same cycle as the strobe, which a design would get wrong by charging that packet to the old microframe. It also lines up a clear with a new error in one cycle, where a clear-wins register would lose the error.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int MAX_PKTS   = 3;
  localparam int CNT_W      = $clog2(MAX_PKTS + 1);
  localparam int STAT_W     = 8;
  localparam int INCOMP_BIT = 2;
  localparam int DERR_BIT   = 3;
  localparam int PERR_BIT   = 4;
  localparam logic [STAT_W-1:0] FLAG_MASK =
    STAT_W'((1 << INCOMP_BIT) | (1 << DERR_BIT) | (1 << PERR_BIT));

  typedef enum logic [1:0] {
    PID_DATA0 = 2'b00,
    PID_DATA1 = 2'b01,
    PID_DATA2 = 2'b10,
    PID_OTHER = 2'b11
  } pid_e;
endpackage

// File: rtl/iso_rx_sticky.sv
module iso_rx_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q_q, q_d, en;

    always_comb begin
      en  = set_i[b] | clr_i[b];
      q_d = set_i[b] | (q_q & ~clr_i[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_q <= 1'b0;
      else if (en) q_q <= q_d;
    end

    assign q_o[b] = q_q;
  end
endmodule

// File: rtl/iso_rx_seq.sv
module iso_rx_seq
  import iso_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       pkt_end,
  input  logic [1:0] pkt_pid,
  output logic       incomp_set,
  output logic       pid_err_set
);
  logic [CNT_W-1:0] cnt_q, cnt_d, exp_q, exp_d;
  logic [CNT_W-1:0] base_cnt, base_exp, want;
  logic             en;
  pid_e             pid;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PKTS);

  always_comb begin
    pid        = pid_e'(pkt_pid);
    en         = sof | pkt_end;
    incomp_set = sof & (cnt_q < exp_q);
    base_cnt   = sof ? '0 : cnt_q;
    base_exp   = sof ? '0 : exp_q;
    want       = base_exp - CNT_W'(1) - base_cnt;
    cnt_d      = base_cnt;
    exp_d      = base_exp;
    pid_err_set = 1'b0;
    if (pkt_end) begin
      if (base_cnt == '0) begin
        unique case (pid)
          PID_DATA2: exp_d = CNT_W'(3);
          PID_DATA1: exp_d = CNT_W'(2);
          PID_DATA0: exp_d = CNT_W'(1);
          default: begin
            exp_d       = '0;
            pid_err_set = 1'b1;
          end
        endcase
      end else if ((base_cnt >= base_exp) || (pkt_pid != 2'(want))) begin
        pid_err_set = 1'b1;
      end
      if (base_cnt != CNT_MAX) cnt_d = base_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/iso_rx_tracker.sv
module iso_rx_tracker
  import iso_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              pkt_end,
  input  logic [1:0]        pkt_pid,
  input  logic              pkt_crc_err,
  input  logic              pkt_stuff_err,
  input  logic              fifo_ack,
  input  logic [STAT_W-1:0] clr_w1c,
  input  logic              irq_ack,
  output logic              fifo_commit,
  output logic [STAT_W-1:0] rx_status,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              incomp_set, pid_err_set;
  logic [STAT_W-1:0] stat_set, stat_clr;
  logic              commit_d, commit_en;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  iso_rx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sof        (sof),
    .pkt_end    (pkt_end),
    .pkt_pid    (pkt_pid),
    .incomp_set (incomp_set),
    .pid_err_set(pid_err_set)
  );

  always_comb begin
    stat_set             = '0;
    stat_set[INCOMP_BIT] = incomp_set;
    stat_set[DERR_BIT]   = pkt_end & (pkt_crc_err | pkt_stuff_err);
    stat_set[PERR_BIT]   = pid_err_set;
    stat_clr             = clr_w1c & FLAG_MASK;
  end

  iso_rx_sticky #(.W(STAT_W)) u_status (
    .clk  (clk),
    .rst_n(rst_int_n),
    .set_i(stat_set),
    .clr_i(stat_clr),
    .q_o  (rx_status)
  );

  iso_rx_sticky #(.W(1)) u_irq (
    .clk  (clk),
    .rst_n(rst_int_n),
    .set_i(fifo_ack),
    .clr_i(irq_ack),
    .q_o  (irq)
  );

  // Every packet is committed, corrupt or not
  always_comb begin
    commit_d  = pkt_end;
    commit_en = pkt_end | fifo_commit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     fifo_commit <= 1'b0;
    else if (commit_en) fifo_commit <= commit_d;
  end
endmodule

// File: rtl/iso_rx_tracker_chk.sv
module iso_rx_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_end,
  input logic [1:0] pkt_pid,
  input logic       pkt_crc_err,
  input logic       pkt_stuff_err,
  input logic       fifo_ack,
  input logic       clr_derr,
  input logic       irq_ack,
  input logic       fifo_commit,
  input logic       derr,
  input logic       perr,
  input logic       irq
);
  assert_commit_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> fifo_commit);

  assert_commit_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_commit |-> $past(pkt_end));

  assert_derr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && (pkt_crc_err || pkt_stuff_err)) |=> derr);

  assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && pkt_pid == 2'b11) |=> perr);

  assert_derr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (derr && !clr_derr) |=> derr);

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ack |=> irq);

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
endmodule

bind iso_rx_tracker iso_rx_tracker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .pkt_end      (pkt_end),
  .pkt_pid      (pkt_pid),
  .pkt_crc_err  (pkt_crc_err),
  .pkt_stuff_err(pkt_stuff_err),
  .fifo_ack     (fifo_ack),
  .clr_derr     (clr_w1c[3]),
  .irq_ack      (irq_ack),
  .fifo_commit  (fifo_commit),
  .derr         (rx_status[3]),
  .perr         (rx_status[4]),
  .irq          (irq)
);

// File: tb/iso_rx_tracker_tb.sv
module iso_rx_tracker_tb;
  logic       clk, rst_n;
  logic       sof, pkt_end, pkt_crc_err, pkt_stuff_err, fifo_ack, irq_ack;
  logic [1:0] pkt_pid;
  logic [7:0] clr_w1c;
  logic       fifo_commit, irq;
  logic [7:0] rx_status;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state, built from the requirements
  int       m_cnt, m_exp;
  bit [7:0] m_stat;
  bit       m_irq, m_commit;

  iso_rx_tracker u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 fifo_commit", 8'(fifo_commit), 8'(m_commit));
    chk("R3 data error bit3", 8'(rx_status[3]), 8'(m_stat[3]));
    chk("R5 incomplete bit2", 8'(rx_status[2]), 8'(m_stat[2]));
    chk("R6 pid error bit4", 8'(rx_status[4]), 8'(m_stat[4]));
    chk("R8 unused status bits", rx_status & 8'hE3, 8'h00);
    chk("R9 irq", 8'(irq), 8'(m_irq));
  endtask

  task automatic model_step();
    int  bc, be;
    bit  perr, inc;
    inc = sof && (m_cnt < m_exp);
    bc  = sof ? 0 : m_cnt;
    be  = sof ? 0 : m_exp;
    perr = 0;
    if (pkt_end) begin
      if (bc == 0) begin
        case (pkt_pid)
          2'b10: be = 3;
          2'b01: be = 2;
          2'b00: be = 1;
          default: begin be = 0; perr = 1; end
        endcase
      end else if (bc >= be || int'(pkt_pid) != be - 1 - bc) perr = 1;
      if (bc < 3) bc++;
    end
    m_cnt = bc;
    m_exp = be;
    m_stat = (m_stat & ~clr_w1c & 8'h1C)
           | {3'b0, perr, pkt_end & (pkt_crc_err | pkt_stuff_err), inc, 2'b0};
    m_irq    = (m_irq & ~irq_ack) | fifo_ack;
    m_commit = pkt_end;
  endtask

  // called at a falling edge: drive, model, wait one cycle, compare
  task automatic cyc(bit s, bit p, bit [1:0] pid, bit crc, bit stf,
                     bit ack, bit [7:0] clr, bit iack);
    sof = s; pkt_end = p; pkt_pid = pid; pkt_crc_err = crc;
    pkt_stuff_err = stf; fifo_ack = ack; clr_w1c = clr; irq_ack = iack;
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    cyc(0, 0, 2'b00, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    sof = 0; pkt_end = 0; pkt_pid = 0; pkt_crc_err = 0; pkt_stuff_err = 0;
    fifo_ack = 0; clr_w1c = 0; irq_ack = 0;
    m_cnt = 0; m_exp = 0; m_stat = 0; m_irq = 0; m_commit = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 status in reset", rx_status, 8'h00);
    chk("R1 irq in reset", 8'(irq), 8'h00);
    chk("R1 commit in reset", 8'(fifo_commit), 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all();

    // R4/R5: DATA2 opener, only two packets, then sof -> incomplete
    cyc(1, 0, 2'b00, 0, 0, 0, 8'h00, 0);
    cyc(0, 1, 2'b10, 0, 0, 0, 8'h00, 0);
    cyc(0, 1, 2'b01, 0, 0, 1, 8'h00, 0);
    cyc(1, 0, 2'b00, 0, 0, 1, 8'h00, 0);
    idle();
    // R8: clear incomplete and irq
    cyc(0, 0, 2'b00, 0, 0, 0, 8'hFF, 1);
    // R4: DATA1, DATA0 complete -> no incomplete at sof
    cyc(0, 1, 2'b01, 0, 0, 0, 8'h00, 0);
    cyc(0, 1, 2'b00, 0, 0, 0, 8'h00, 0);
    cyc(1, 0, 2'b00, 0, 0, 0, 8'h00, 0);
    // R4/R5: DATA1 opener with nothing after -> incomplete
    cyc(0, 1, 2'b01, 0, 0, 0, 8'h00, 0);
    cyc(1, 0, 2'b00, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 2'b00, 0, 0, 0, 8'h04, 0);
    // R6: DATA0 repeated -> extra packet, pid error
    cyc(0, 1, 2'b00, 0, 0, 0, 8'h00, 0);
    cyc(0, 1, 2'b00, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 2'b00, 0, 0, 0, 8'h10, 0);
    // R6: DATA2 then DATA0 (skipped DATA1)
    cyc(1, 1, 2'b10, 0, 0, 0, 8'h00, 0);  // R7: packet with sof starts new frame
    cyc(0, 1, 2'b00, 0, 0, 0, 8'h00, 0);
    cyc(0, 0, 2'b00, 0, 0, 0, 8'h10, 0);
    // R6: reserved code
    cyc(1, 1, 2'b11, 0, 0, 0, 8'h00, 0);
    // R3: CRC and stuff errors still commit, irq still raised (R9)
    cyc(1, 1, 2'b00, 1, 0, 1, 8'h00, 0);
    cyc(0, 0, 2'b00, 0, 0, 0, 8'h08, 1);
    cyc(1, 1, 2'b00, 0, 1, 0, 8'h00, 0);
    // R8: clear and set in the same cycle -> set wins
    cyc(1, 1, 2'b00, 1, 0, 1, 8'h08, 1);
    idle();
    // R8: clears on unused bits have no effect
    cyc(0, 0, 2'b00, 0, 0, 0, 8'hE3, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [1:0] rp;
      rp = 2'($urandom_range(0, 7) == 0 ? 3 : $urandom_range(0, 2));
      cyc($urandom_range(0, 7) == 0,
          $urandom_range(0, 2) == 0,
          rp,
          $urandom_range(0, 9) == 0,
          $urandom_range(0, 11) == 0,
          $urandom_range(0, 3) == 0,
          ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00,
          $urandom_range(0, 5) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule